// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a 10 MHz reference clock into a 32,768 Hz square wave whose average frequency is exact over every one-second frame. A single integer divider cannot do this. Instead, each half-period of the output is one of two lengths. A long half-period is 39 units and a short one is 38 units, where one unit is four reference clocks. Each frame has 65,536 half-periods. The first 9,632 are long and the remaining 55,904 are short, so 10,000,000 reference clocks produce exactly 65,536 output edges. The output therefore carries a small, fixed and repeating frequency modulation.

A one-cycle strobe marks the first clock of each frame. A monitor output gives a 1 Hz square wave, which is the output divided by 2^15. An oscilloscope triggered by an ideal one-pulse-per-second reference can watch this monitor edge for drift. One unit of 400 ns added per second would move that edge by 24 µs per minute. All lengths are parameters, and the bench uses a scaled-down frame.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `wave_out`, `frame_start` and `mon_1hz` are all low.
- R2: Every interval in which `wave_out` holds one value lasts either UNIT_CLKS*LONG_UNITS clocks (156 by default) or UNIT_CLKS*SHORT_UNITS clocks (152 by default).
- R3: Within a frame of 2^IDX_W half-periods, those at index 0 to LONG_HALVES-1 (9,632 by default) are long and all later ones are short.
- R4: `frame_start` is high for exactly one clock, in the first cycle of each new frame, which is the cycle in which `wave_out` has just fallen. Successive strobes are exactly LONG_HALVES*long + (2^IDX_W-LONG_HALVES)*short clocks apart, which is 10,000,000 by default.
- R5: After the last short half-period of a frame, the next half-period is long again, and the pattern repeats without end.
- R6: `mon_1hz` is low during half-periods 0 to 2^(IDX_W-1)-1 of a frame and high during the rest. It therefore changes only together with `wave_out`, and it completes one full cycle per frame.
- R7: The first half-period after reset is long and gives no `frame_start`. `wave_out` first rises exactly one long half-period after the last clock edge at which reset was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (10 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| wave_out | output | 1 | Fractionally divided square wave (32,768 Hz average) |
| frame_start | output | 1 | One-cycle strobe in the first cycle of each frame |
| mon_1hz | output | 1 | Once-per-frame monitor square wave |

## Verification
The assertions check on every cycle the properties that need only local history:
- each run of `wave_out` has one of the two legal lengths;
- a run never grows past the long length;
- `frame_start` only appears on a falling edge of the output, with the monitor low;
- the monitor never changes unless `wave_out` does;
- frame strobes are exactly one frame length apart.

Only the bench's scenarios can show that the long/short choices appear in the right order and number. These scenarios are the long run at the start of each frame, the switch to short lengths at the right index, and the return to long after the last short half-period. The bench also shows where the monitor changes within the frame and that a reset in mid-frame restarts the sequence from its first long half-period.

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int UNIT_CLKS   = 4,
  parameter int LONG_UNITS  = 39,
  parameter int SHORT_UNITS = 38,
  parameter int IDX_W       = 16,
  parameter int LONG_HALVES = 9632
) (
  input  logic clk,
  input  logic rst,
  output logic wave_out,
  output logic frame_start,
  output logic mon_1hz
);
  localparam int LONG_CLKS  = UNIT_CLKS * LONG_UNITS;
  localparam int SHORT_CLKS = UNIT_CLKS * SHORT_UNITS;
  localparam int CNT_W      = $clog2(LONG_CLKS);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CLKS - 1);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CLKS - 1);
  localparam logic [IDX_W-1:0] LONG_LIM = IDX_W'(LONG_HALVES);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_nxt;
  logic             last;

  assign last    = (cnt == '0);
  assign idx_nxt = idx + IDX_W'(1);
  assign mon_1hz = idx[IDX_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= LONG_LD;
      idx         <= '0;
      wave_out    <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      if (last) begin
        wave_out    <= ~wave_out;
        idx         <= idx_nxt;
        cnt         <= (idx_nxt < LONG_LIM) ? LONG_LD : SHORT_LD;
        frame_start <= &idx;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
  parameter int UNIT_CLKS   = 4,
  parameter int LONG_UNITS  = 39,
  parameter int SHORT_UNITS = 38,
  parameter int IDX_W       = 16,
  parameter int LONG_HALVES = 9632
) (
  input logic clk,
  input logic rst,
  input logic wave_out,
  input logic frame_start,
  input logic mon_1hz
);
  localparam int LONG_CLKS  = UNIT_CLKS * LONG_UNITS;
  localparam int SHORT_CLKS = UNIT_CLKS * SHORT_UNITS;
  localparam int FRAME_CLKS = LONG_HALVES * LONG_CLKS + ((1 << IDX_W) - LONG_HALVES) * SHORT_CLKS;

  logic        wave_q;
  logic        chg;
  logic [31:0] run;
  logic [31:0] frun;

  assign chg = (wave_out != wave_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
      run    <= '0;
      frun   <= '0;
    end else begin
      wave_q <= wave_out;
      run    <= chg ? 32'd1 : run + 32'd1;
      frun   <= frame_start ? 32'd1 : frun + 32'd1;
    end
  end

  a_r2_half_len: assert property (@(posedge clk) disable iff (rst)
    chg |-> (run == 32'(LONG_CLKS) || run == 32'(SHORT_CLKS)));

  a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
    run <= 32'(LONG_CLKS));

  a_r4_strobe_on_fall: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (chg && !wave_out && !mon_1hz));

  a_r4_frame_len: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (frun == 32'(FRAME_CLKS)));

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  a_r6_mon_with_wave: assert property (@(posedge clk) disable iff (rst)
    (mon_1hz != $past(mon_1hz)) |-> chg);
endmodule

bind frac_clk_div frac_clk_div_chk #(
  .UNIT_CLKS(UNIT_CLKS), .LONG_UNITS(LONG_UNITS), .SHORT_UNITS(SHORT_UNITS),
  .IDX_W(IDX_W), .LONG_HALVES(LONG_HALVES)
) u_chk (.*);

// File: tb/tb_frac_clk_div.sv
`timescale 1ns/1ps
module tb_frac_clk_div;
  localparam int UNIT_CLKS = 4, LONG_UNITS = 39, SHORT_UNITS = 38;
  localparam int IDX_W = 8, LONG_HALVES = 37;
  localparam int LONG_CLKS  = UNIT_CLKS * LONG_UNITS;
  localparam int SHORT_CLKS = UNIT_CLKS * SHORT_UNITS;
  localparam int HALVES     = 1 << IDX_W;
  localparam int FRAME_CLKS = 37 * 156 + (256 - 37) * 152;

  logic clk = 1'b0, rst = 1'b1;
  logic wave_out, frame_start, mon_1hz;

  frac_clk_div #(.UNIT_CLKS(UNIT_CLKS), .LONG_UNITS(LONG_UNITS), .SHORT_UNITS(SHORT_UNITS),
                 .IDX_W(IDX_W), .LONG_HALVES(LONG_HALVES)) dut (
    .clk(clk), .rst(rst), .wave_out(wave_out), .frame_start(frame_start), .mon_1hz(mon_1hz));

  always #4 clk = ~clk;

  typedef struct { int len; bit mon; bit strb; } item_t;
  item_t q[$];
  item_t cur;
  int checks = 0, fails = 0, cyc = 0;
  bit mon_en = 0, started = 0, have = 0, prev;
  int run, bad, fclk, halves_done = 0, nstrobes = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_halves(int n);
    for (int i = 0; i < n; i++) begin
      item_t it;
      int fi = i % HALVES;
      it.len  = (fi < LONG_HALVES) ? LONG_CLKS : SHORT_CLKS;
      it.mon  = (fi >= HALVES / 2);
      it.strb = (fi == 0) && (i != 0);
      q.push_back(it);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic sample_run;
    if (have) begin
      if (mon_1hz != cur.mon) bad++;
      if (frame_start != (cur.strb && run == 1)) bad++;
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (!started) begin
        started = 1; prev = wave_out; run = 1; fclk = 0; bad = 0;
        have = (q.size() > 0);
        if (have) cur = q.pop_front();
        sample_run();
      end else begin
        fclk++;
        if (wave_out == prev) run++;
        else begin
          if (have) begin
            if (halves_done == 0) check(run == cur.len, "R7 first half-period long", run, cur.len);
            else if (cur.strb)    check(run == cur.len, "R5 restart long", run, cur.len);
            else                  check(run == cur.len, "R2/R3 half-period length", run, cur.len);
            check(bad == 0, "R6/R4 monitor and strobe within half-period", bad, 0);
            halves_done++;
          end
          prev = wave_out; run = 1; bad = 0;
          have = (q.size() > 0);
          if (have) cur = q.pop_front();
        end
        sample_run();
        if (frame_start) begin
          check(fclk == FRAME_CLKS, "R4 frame length", fclk, FRAME_CLKS);
          nstrobes++;
          fclk = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      report();
    end
  end

  initial begin
    int total;
    repeat (4) @(negedge clk);
    check(wave_out == 0, "R1 wave in reset", wave_out, 0);
    check(frame_start == 0, "R1 strobe in reset", frame_start, 0);
    check(mon_1hz == 0, "R1 monitor in reset", mon_1hz, 0);
    total = 2 * HALVES + 20;
    push_halves(total);
    @(posedge clk); #1; rst = 0; mon_en = 1;
    @(negedge clk);
    check(wave_out == 0 && frame_start == 0 && mon_1hz == 0, "R1 after release",
          {wave_out, frame_start, mon_1hz}, 0);
    wait (halves_done == total);
    check(nstrobes == 2, "R4 strobe count", nstrobes, 2);

    @(posedge clk); #1; rst = 1; mon_en = 0;
    repeat (3) @(negedge clk);
    check(wave_out == 0, "R1 wave in mid-run reset", wave_out, 0);
    check(frame_start == 0, "R1 strobe in mid-run reset", frame_start, 0);
    check(mon_1hz == 0, "R1 monitor in mid-run reset", mon_1hz, 0);
    q.delete(); started = 0; halves_done = 0; nstrobes = 0;
    push_halves(12);
    @(posedge clk); #1; rst = 0; mon_en = 1;
    wait (halves_done == 12);
    check(nstrobes == 0, "R7 no strobe after reset", nstrobes, 0);
    report();
  end
endmodule